// File: doc/BRIEF.md
# SWD Link Connect Sequencer

This block takes a debug target from an unknown wire state into a working Serial Wire Debug link. When asked to connect, it takes over the SWCLK and SWDIO pins. It clocks out a fixed switch pattern: a long run of ones, a 16-bit switch code, a second long run of ones, and a short run of driven-low idle bits. All bits go out at a SWCLK rate set at run time. The sequence is always run in full, even when the target already seems to be talking SWD. The line reset inside the pattern leaves the target's debug port waiting for an identification read before it will accept anything else.

When the last idle bit has been sent, the sequencer passes the pins to a separate transaction engine. It asks that engine for one read of the identification register, using the request byte 0xA5. It then waits for the engine's completion. The engine's status and read data become the result of the connect. The link counts as up only when that read completes with an OK acknowledge and good parity, which the engine reports as status code 0.

Top module: `swd_connect_seq`

## Requirements
- R1: After reset, busy, done, txn_start and link_up are 0, swclk is 1 and swdio_oe is 0.
- R2: The first 64 bits sent after a connect request are all 1.
- R3: The next 16 bits are the switch code 0xE79E, sent least significant bit first.
- R4: The next 64 bits after the switch code are all 1.
- R5: The last 8 bits of the pattern are 0. After them no further pattern bit is sent before txn_start.
- R6: Each bit sets swdio_out while swclk is low. Every low phase and every high phase of swclk lasts clk_div+1 clock cycles. swdio_out does not change while swclk is high.
- R7: One cycle after the last high phase ends, txn_start pulses for exactly one cycle and txn_cmd reads 0xA5. From then until done, swclk, swdio_out and swdio_oe follow the engine-side pin inputs.
- R8: done is a one-cycle pulse. It comes one cycle after txn_done is sampled while waiting for the engine, and it carries status = txn_status and idcode = txn_rdata. A txn_done at any other time is ignored.
- R9: link_up is 1 after a done only if status is 0 (OK). Codes 1 = wait timeout, 2 = fault, 3 = no response and 4 = parity error all leave link_up at 0.
- R10: Every connect request runs the whole pattern again and clears link_up when it starts. A connect_req seen while busy has no effect.
- R11: Whenever busy is 0, swclk is 1 and swdio_oe is 0, so SWDIO is tri-stated.
- R12: swdio_oe is 1 for the whole pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| connect_req | input | 1 | Start a connect sequence (sampled when idle) |
| clk_div | input | DIV_W | SWCLK half-period minus one, in clk cycles |
| busy | output | 1 | High from start of pattern until done |
| done | output | 1 | One-cycle completion pulse |
| status | output | STAT_W | Status of the identification read |
| idcode | output | DATA_W | Identification value read |
| link_up | output | 1 | Last connect succeeded |
| txn_start | output | 1 | Start pulse to the transaction engine |
| txn_cmd | output | 8 | Request byte for the engine (0xA5) |
| txn_done | input | 1 | Engine completion strobe |
| txn_status | input | STAT_W | Engine status code |
| txn_rdata | input | DATA_W | Engine read data |
| eng_swclk | input | 1 | Engine SWCLK, passed through while waiting |
| eng_swdio_out | input | 1 | Engine SWDIO data, passed through while waiting |
| eng_swdio_oe | input | 1 | Engine SWDIO enable, passed through while waiting |
| swclk | output | 1 | SWCLK pin |
| swdio_out | output | 1 | SWDIO output data |
| swdio_oe | output | 1 | SWDIO output enable |

## Verification
The first SWCLK low phase begins in the cycle after the request is sampled. Each later half-phase of SWCLK is due exactly clk_div+1 cycles after the one before it. txn_start comes in the cycle after the final high phase ends, and done comes one cycle after the engine strobe. Inputs are driven and outputs sampled on the falling clock edge. The scoreboard pops one expected bit on each observed rising edge of SWCLK and measures each phase length against clk_div+1. It pops one expected result on each done, and checks that done drops on the next sample.

// File: rtl/swd_conn_pkg.sv
package swd_conn_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_SHIFT = 2'd1,
      SEQ_XFER  = 2'd2
   } seq_state_t;

   // transaction engine status codes
   localparam logic [2:0] LINK_OK        = 3'd0;
   localparam logic [2:0] LINK_WAIT_TMO  = 3'd1;
   localparam logic [2:0] LINK_FAULT     = 3'd2;
   localparam logic [2:0] LINK_NO_RESP   = 3'd3;
   localparam logic [2:0] LINK_PARITY    = 3'd4;

endpackage

// File: rtl/swd_halfclk.sv
// Half-period timer: tick marks the last cycle of each SWCLK phase.
module swd_halfclk #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/swd_bitpat.sv
// Switch pattern lookup: ones, switch code (LSB first), ones, zeros.
module swd_bitpat #(
   parameter int          PRE_ONES   = 64,
   parameter int          CODE_W     = 16,
   parameter logic [CODE_W-1:0] CODE = 16'hE79E,
   parameter int          POST_ONES  = 64,
   parameter int          IDLE_ZEROS = 8,
   parameter int          IDX_W      = 8
) (
   input  logic [IDX_W-1:0] idx,
   output logic             bit_o
);
   localparam int TOTAL = PRE_ONES + CODE_W + POST_ONES + IDLE_ZEROS;
   localparam int PADDED = 1 << IDX_W;

   logic [PADDED-1:0] pat;

   for (genvar i = 0; i < PADDED; i++) begin : g_pat
      if (i < PRE_ONES) begin : g_pre
         assign pat[i] = 1'b1;
      end else if (i < PRE_ONES + CODE_W) begin : g_code
         assign pat[i] = CODE[i-PRE_ONES];
      end else if (i < PRE_ONES + CODE_W + POST_ONES) begin : g_post
         assign pat[i] = 1'b1;
      end else begin : g_zero
         assign pat[i] = 1'b0;
      end
   end

   assign bit_o = pat[idx];

   if (TOTAL > PADDED) begin : g_bad_idx
      $error("swd_bitpat: IDX_W too narrow for pattern length");
   end
endmodule

// File: rtl/swd_connect_seq.sv
module swd_connect_seq
   import swd_conn_pkg::*;
#(
   parameter int          DIV_W      = 8,
   parameter int          DATA_W     = 32,
   parameter int          STAT_W     = 3,
   parameter int          PRE_ONES   = 64,
   parameter int          CODE_W     = 16,
   parameter logic [CODE_W-1:0] CODE = 16'hE79E,
   parameter int          POST_ONES  = 64,
   parameter int          IDLE_ZEROS = 8,
   parameter logic [7:0]  ID_REQ     = 8'hA5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              connect_req,
   input  logic [DIV_W-1:0]  clk_div,
   output logic              busy,
   output logic              done,
   output logic [STAT_W-1:0] status,
   output logic [DATA_W-1:0] idcode,
   output logic              link_up,
   output logic              txn_start,
   output logic [7:0]        txn_cmd,
   input  logic              txn_done,
   input  logic [STAT_W-1:0] txn_status,
   input  logic [DATA_W-1:0] txn_rdata,
   input  logic              eng_swclk,
   input  logic              eng_swdio_out,
   input  logic              eng_swdio_oe,
   output logic              swclk,
   output logic              swdio_out,
   output logic              swdio_oe
);
   localparam int TOTAL_BITS = PRE_ONES + CODE_W + POST_ONES + IDLE_ZEROS;
   localparam int IDX_W      = $clog2(TOTAL_BITS);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL_BITS - 1);

   if (DIV_W < 1 || STAT_W < 3 || PRE_ONES < 1 || CODE_W < 1 || TOTAL_BITS < 2) begin : g_bad_cfg
      $error("swd_connect_seq: illegal parameter set");
   end

   seq_state_t       state_q;
   logic [IDX_W-1:0] bit_idx_q;
   logic [IDX_W-1:0] next_idx;
   logic             phase_hi_q;
   logic             swclk_q;
   logic             dout_q;
   logic             next_bit;
   logic             tick;
   logic             shifting;

   assign shifting = (state_q == SEQ_SHIFT);
   assign next_idx = (state_q == SEQ_IDLE) ? '0 : bit_idx_q + 1'b1;

   swd_halfclk #(.DIV_W(DIV_W)) i_halfclk (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (shifting),
      .div   (clk_div),
      .tick  (tick)
   );

   swd_bitpat #(
      .PRE_ONES   (PRE_ONES),
      .CODE_W     (CODE_W),
      .CODE       (CODE),
      .POST_ONES  (POST_ONES),
      .IDLE_ZEROS (IDLE_ZEROS),
      .IDX_W      (IDX_W)
   ) i_bitpat (
      .idx   (next_idx),
      .bit_o (next_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= SEQ_IDLE;
         bit_idx_q  <= '0;
         phase_hi_q <= 1'b0;
         swclk_q    <= 1'b1;
         dout_q     <= 1'b1;
         txn_start  <= 1'b0;
         done       <= 1'b0;
         status     <= '0;
         idcode     <= '0;
         link_up    <= 1'b0;
      end else begin
         txn_start <= 1'b0;
         done      <= 1'b0;
         unique case (state_q)
            SEQ_IDLE: begin
               if (connect_req) begin
                  state_q    <= SEQ_SHIFT;
                  bit_idx_q  <= '0;
                  phase_hi_q <= 1'b0;
                  swclk_q    <= 1'b0;
                  dout_q     <= next_bit;
                  link_up    <= 1'b0;
               end
            end
            SEQ_SHIFT: begin
               if (tick) begin
                  if (!phase_hi_q) begin
                     phase_hi_q <= 1'b1;
                     swclk_q    <= 1'b1;
                  end else if (bit_idx_q == LAST_IDX) begin
                     state_q   <= SEQ_XFER;
                     txn_start <= 1'b1;
                  end else begin
                     phase_hi_q <= 1'b0;
                     swclk_q    <= 1'b0;
                     bit_idx_q  <= next_idx;
                     dout_q     <= next_bit;
                  end
               end
            end
            SEQ_XFER: begin
               if (txn_done) begin
                  state_q <= SEQ_IDLE;
                  done    <= 1'b1;
                  status  <= txn_status;
                  idcode  <= txn_rdata;
                  link_up <= (txn_status == STAT_W'(LINK_OK));
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (state_q)
         SEQ_SHIFT: begin
            swclk     = swclk_q;
            swdio_out = dout_q;
            swdio_oe  = 1'b1;
         end
         SEQ_XFER: begin
            swclk     = eng_swclk;
            swdio_out = eng_swdio_out;
            swdio_oe  = eng_swdio_oe;
         end
         default: begin
            swclk     = 1'b1;
            swdio_out = 1'b1;
            swdio_oe  = 1'b0;
         end
      endcase
   end

   assign busy    = (state_q != SEQ_IDLE);
   assign txn_cmd = ID_REQ;

endmodule

// File: rtl/swd_connect_chk.sv
module swd_connect_chk #(
   parameter int STAT_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              txn_start,
   input logic              link_up,
   input logic [STAT_W-1:0] status,
   input logic              swclk,
   input logic              swdio_out,
   input logic              swdio_oe,
   input logic              shifting
);
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r7_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      txn_start |=> !txn_start);

   a_r7_start_after_shift: assert property (@(posedge clk) disable iff (!rst_n)
      txn_start |-> $past(shifting));

   a_r9_link_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
      link_up |-> (status == '0));

   a_r11_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (swclk && !swdio_oe));

   a_r12_drive_in_shift: assert property (@(posedge clk) disable iff (!rst_n)
      shifting |-> swdio_oe);

   a_r6_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
      (shifting && $past(shifting) && swclk && $past(swclk)) |-> $stable(swdio_out));
endmodule

bind swd_connect_seq swd_connect_chk #(.STAT_W(STAT_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .txn_start (txn_start),
   .link_up   (link_up),
   .status    (status),
   .swclk     (swclk),
   .swdio_out (swdio_out),
   .swdio_oe  (swdio_oe),
   .shifting  (shifting)
);

// File: tb/test_swd_connect_seq.sv
`timescale 1ns/1ps
module test_swd_connect_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        connect_req = 1'b0;
   logic [7:0]  clk_div = 8'd0;
   logic        busy, done, link_up, txn_start;
   logic [2:0]  status;
   logic [31:0] idcode;
   logic [7:0]  txn_cmd;
   logic        txn_done = 1'b0;
   logic [2:0]  txn_status = 3'd0;
   logic [31:0] txn_rdata = 32'd0;
   logic        eng_swclk = 1'b1;
   logic        eng_swdio_out = 1'b1;
   logic        eng_swdio_oe = 1'b0;
   logic        swclk, swdio_out, swdio_oe;

   always #2 clk = ~clk;

   swd_connect_seq i_swd_connect_seq (
      .clk(clk), .rst_n(rst_n), .connect_req(connect_req), .clk_div(clk_div),
      .busy(busy), .done(done), .status(status), .idcode(idcode), .link_up(link_up),
      .txn_start(txn_start), .txn_cmd(txn_cmd), .txn_done(txn_done),
      .txn_status(txn_status), .txn_rdata(txn_rdata),
      .eng_swclk(eng_swclk), .eng_swdio_out(eng_swdio_out), .eng_swdio_oe(eng_swdio_oe),
      .swclk(swclk), .swdio_out(swdio_out), .swdio_oe(swdio_oe)
   );

   typedef struct { logic [2:0] st; logic [31:0] id; } res_t;

   int   n_cmp = 0;
   int   n_bad = 0;
   bit   exp_bits[$];
   res_t exp_res[$];
   int   cur_div = 0;
   logic [2:0]  eng_st = 3'd0;
   logic [31:0] eng_id = 32'd0;
   bit   eng_active = 1'b0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   logic prev_swclk = 1'b1;
   int   run_len = 0;
   logic done_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n && busy && !txn_start && !eng_active) begin
         chk(swdio_oe == 1'b1, "R12 oe during pattern", swdio_oe, 1);
         if (swclk != prev_swclk) begin
            if (run_len > 0)
               chk(run_len == cur_div + 1, "R6 phase length", run_len, cur_div + 1);
            if (swclk) begin
               if (exp_bits.size() == 0)
                  chk(1'b0, "R10 unexpected extra pattern bit", swdio_out, 0);
               else begin
                  bit e;
                  e = exp_bits.pop_front();
                  chk(swdio_out == e, "R2/R3/R4/R5 pattern bit", swdio_out, e);
               end
               chk(link_up == 1'b0, "R10 link_up cleared at restart", link_up, 0);
            end
            run_len = 1;
         end else begin
            run_len++;
         end
      end else begin
         run_len = 0;
      end
      prev_swclk = swclk;

      if (rst_n && done) begin
         if (exp_res.size() == 0)
            chk(1'b0, "R8 unexpected done", 1, 0);
         else begin
            res_t r;
            r = exp_res.pop_front();
            chk(status == r.st, "R8 status", status, r.st);
            chk(idcode == r.id, "R8 idcode", idcode, r.id);
            chk(link_up == (r.st == 3'd0), "R9 link_up", link_up, r.st == 3'd0);
         end
      end
      if (done_prev)
         chk(done == 1'b0, "R8 done one cycle", done, 0);
      done_prev = done;
   end

   // transaction engine model
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && txn_start) begin
            eng_active = 1'b1;
            chk(txn_cmd == 8'hA5, "R7 request byte", txn_cmd, 8'hA5);
            chk(exp_bits.size() == 0, "R5 all bits sent before start", exp_bits.size(), 0);
            @(negedge clk);
            chk(txn_start == 1'b0, "R7 start one cycle", txn_start, 0);
            eng_swclk = 1'b0; eng_swdio_oe = 1'b1; eng_swdio_out = 1'b0;
            @(negedge clk);
            chk(swclk == 1'b0 && swdio_oe == 1'b1 && swdio_out == 1'b0,
                "R7 pins follow engine", {swclk, swdio_oe, swdio_out}, 3'b010);
            eng_swclk = 1'b1; eng_swdio_oe = 1'b0; eng_swdio_out = 1'b1;
            repeat (3) @(negedge clk);
            txn_status = eng_st; txn_rdata = eng_id; txn_done = 1'b1;
            @(negedge clk);
            txn_done = 1'b0;
            eng_active = 1'b0;
         end
      end
   end

   task automatic do_connect(input int d, input logic [2:0] st, input logic [31:0] id, input int hold);
      res_t r;
      cur_div = d;
      clk_div = 8'(d);
      eng_st = st;
      eng_id = id;
      for (int i = 0; i < 64; i++) exp_bits.push_back(1'b1);
      for (int i = 0; i < 16; i++) exp_bits.push_back(bit'((16'hE79E >> i) & 1));
      for (int i = 0; i < 64; i++) exp_bits.push_back(1'b1);
      for (int i = 0; i < 8; i++)  exp_bits.push_back(1'b0);
      r.st = st; r.id = id;
      exp_res.push_back(r);
      @(negedge clk);
      connect_req = 1'b1;
      repeat (hold) @(negedge clk);
      connect_req = 1'b0;
      wait (exp_res.size() == 0);
      repeat (2) @(negedge clk);
      chk(busy == 1'b0, "R11 busy low after done", busy, 0);
      chk(swclk == 1'b1 && swdio_oe == 1'b0, "R11 idle pins", {swclk, swdio_oe}, 2'b10);
      chk(exp_bits.size() == 0, "R2 whole pattern sent", exp_bits.size(), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 0 && done == 0 && txn_start == 0 && link_up == 0, "R1 reset outputs",
          {busy, done, txn_start, link_up}, 0);
      chk(swclk == 1 && swdio_oe == 0, "R1 reset pins", {swclk, swdio_oe}, 2'b10);

      // stray engine strobe while idle
      txn_done = 1'b1; txn_status = 3'd2;
      @(negedge clk);
      txn_done = 1'b0;
      @(negedge clk);
      chk(done == 0 && busy == 0, "R8 stray txn_done ignored", {done, busy}, 0);

      do_connect(0, 3'd0, 32'h2BA0_1477, 1);
      do_connect(1, 3'd0, 32'h0BC1_1477, 1);   // re-run after success
      do_connect(2, 3'd2, 32'hDEAD_0001, 12);  // request held while busy
      do_connect(0, 3'd4, 32'h1234_5678, 1);   // parity error
      do_connect(3, 3'd3, 32'h0000_0000, 1);   // no response

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule